// File: doc/BRIEF.md
# GPIO Runtime Port Window

This block is the run-time register window of a general-purpose I/O unit on a byte-wide I/O bus. Four byte-wide ports share a 16-byte window. The window starts at a base address that the configuration logic supplies, and it answers only while the unit's activate flag is high. Each port has up to four registers: output data, synchronized input data, event enable and event status.

Software drives pins by writing the output registers. Because those registers read back, software can set or clear a single pin with a read-modify-write. Inputs pass through a two-flop synchronizer before they are read.

Only the two lower ports detect events. A rising edge on an enabled, synchronized input latches a status bit, and a single summary line stays high while any status bit is set.

Top module: `gpio_window_bank`

## Requirements
- R1: After reset, every register is 0x00, `pin_out` is all zeros and `evt_irq` is low.
- R2: `io_hit` is high exactly when `win_active` is high and `win_base <= io_addr < win_base + 16`. Without a hit, writes change nothing and `io_rdata` is 0x00.
- R3: Ports 0..3 begin at window offsets 0, 4, 8 and 10. Inside a port, +0 is output data, +1 is input data, +2 is event enable and +3 is event status. Where two ports' slots coincide (offsets 10 and 11), the higher-numbered port owns the slot, so offsets 10 and 11 are port 3's output and input.
- R4: The output register of port p drives `pin_out[8p+7:8p]` from the clock edge that captures the write. Reading it returns the last value written.
- R5: The input register returns `pin_in` through two flops. A pin change made between edges is still invisible to a read after one rising edge and is visible after the second.
- R6: On ports 0 and 1, an event status bit sets on a rising edge of its synchronized input while its enable bit is 1. Falling edges, and edges on bits whose enable is 0, leave status unchanged.
- R7: Writing a 1 to an event status bit clears it. Writing a 0 to a status bit leaves it as it is.
- R8: Event enable and status registers of ports 2 and 3 (port 3's sit at offsets 12 and 13) read 0x00, ignore writes and never raise `evt_irq`.
- R9: `evt_irq` is high whenever any event status bit is 1, and it falls only after a status-clearing write.
- R10: Window offsets 14 and 15 hold no register. They read 0x00 and writes to them change nothing.
- R11: `io_rdata` is combinational in the cycle that `io_rd` is high, and is 0x00 while `io_rd` is low.
- R12: Flat pin index n maps to port n[4:3] and bit n[2:0]; that pin is `pin_out[n]` and `pin_in[n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_base | input | 16 | Window base address from configuration |
| win_active | input | 1 | Unit activate flag; window decoded only when high |
| io_addr | input | 16 | Bus address |
| io_wr | input | 1 | Write strobe, captured on the rising edge |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| io_hit | output | 1 | Address falls inside the active window |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Pin output levels |
| evt_irq | output | 1 | Summary of all event status bits |

## Verification
The bench targets the overlap at offsets 10 and 11. A decoder with the wrong priority would write port 2's event logic or its output instead of port 3's pins. It checks the synchronizer latency on both sides, so a missing or extra flop shows up as an input read that arrives one cycle early or late. Event tests drive falling edges, disabled bits and write-0 patterns, which a wrong edge detector or a clear-on-any-write bug would turn into a wrong status byte or a stuck `evt_irq`. Random single-pin read-modify-writes through the flat index, random input patterns and random addresses around both window edges catch off-by-one decode bounds and leakage while the unit is inactive.

// File: rtl/gpio_win_pkg.sv
package gpio_win_pkg;
    localparam int NPORTS     = 4;
    localparam int PORT_W     = 8;
    localparam int WIN_BYTES  = 16;
    localparam int WIN_OFF_W  = $clog2(WIN_BYTES);
    localparam int PIDX_W     = $clog2(NPORTS);
    localparam int PINS       = NPORTS * PORT_W;

    typedef enum logic [1:0] {
        REG_OUT  = 2'd0,
        REG_IN   = 2'd1,
        REG_EVEN = 2'd2,
        REG_EVST = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic              hit;
        logic              occupied;
        logic [PIDX_W-1:0] port;
        reg_kind_e         kind;
    } win_sel_t;

    function automatic logic [WIN_OFF_W-1:0] port_base(input int p);
        case (p)
            0:       return WIN_OFF_W'(0);
            1:       return WIN_OFF_W'(4);
            2:       return WIN_OFF_W'(8);
            default: return WIN_OFF_W'(10);
        endcase
    endfunction

    function automatic bit evt_capable(input int p);
        return p < 2;
    endfunction
endpackage

// File: rtl/gpio_win_decode.sv
module gpio_win_decode
    import gpio_win_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              active,
    output win_sel_t          sel
);
    logic [ADDR_W-1:0]    off;
    logic [WIN_OFF_W-1:0] rel;

    always_comb begin
        off = addr - base;
        rel = '0;
        sel = '0;
        sel.hit = active && (addr >= base) && (off < ADDR_W'(WIN_BYTES));
        if (sel.hit) begin
            // ascending scan: a later port overrides, so the higher index owns overlaps
            for (int p = 0; p < NPORTS; p++) begin
                rel = off[WIN_OFF_W-1:0] - port_base(p);
                if (rel <= WIN_OFF_W'(3)) begin
                    sel.occupied = 1'b1;
                    sel.port     = PIDX_W'(p);
                    sel.kind     = reg_kind_e'(rel[1:0]);
                end
            end
        end
    end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_win_pkg::*;
#(
    parameter bit HAS_EVT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_out,
    input  logic              wr_en,
    input  logic              wr_st,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] pin_s,
    output logic [PORT_W-1:0] out_q,
    output logic [PORT_W-1:0] en_q,
    output logic [PORT_W-1:0] st_q
);
    always_ff @(posedge clk) begin
        if (rst)         out_q <= '0;
        else if (wr_out) out_q <= wdata;
    end

    generate
        if (HAS_EVT) begin : g_evt
            logic [PORT_W-1:0] prev_q, en_r, st_r, rise, clr;
            assign rise = pin_s & ~prev_q;
            assign clr  = wr_st ? wdata : '0;
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= '0;
                    en_r   <= '0;
                    st_r   <= '0;
                end else begin
                    prev_q <= pin_s;
                    if (wr_en) en_r <= wdata;
                    st_r <= (st_r & ~clr) | (rise & en_r);
                end
            end
            assign en_q = en_r;
            assign st_q = st_r;
        end else begin : g_noevt
            logic unused_inputs;
            assign unused_inputs = ^{wr_en, wr_st, pin_s};
            assign en_q = '0;
            assign st_q = '0;
        end
    endgenerate
endmodule

// File: rtl/gpio_window_bank.sv
module gpio_window_bank
    import gpio_win_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] win_base,
    input  logic              win_active,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_hit,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic              evt_irq
);
    win_sel_t          sel;
    logic [PINS-1:0]   pin_s;
    logic [PORT_W-1:0] out_a [NPORTS];
    logic [PORT_W-1:0] en_a  [NPORTS];
    logic [PORT_W-1:0] st_a  [NPORTS];
    logic [NPORTS-1:0] port_evt;
    logic              wr_go;

    gpio_win_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(io_addr), .base(win_base), .active(win_active), .sel(sel)
    );

    gpio_sync2 #(.W(PINS)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
    );

    assign wr_go  = io_wr && sel.occupied;
    assign io_hit = sel.hit;

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            logic sel_me;
            assign sel_me = wr_go && (sel.port == PIDX_W'(p));
            gpio_port #(.HAS_EVT(evt_capable(p))) u_port (
                .clk   (clk),
                .rst   (rst),
                .wr_out(sel_me && sel.kind == REG_OUT),
                .wr_en (sel_me && sel.kind == REG_EVEN),
                .wr_st (sel_me && sel.kind == REG_EVST),
                .wdata (io_wdata),
                .pin_s (pin_s[p*PORT_W +: PORT_W]),
                .out_q (out_a[p]),
                .en_q  (en_a[p]),
                .st_q  (st_a[p])
            );
            assign pin_out[p*PORT_W +: PORT_W] = out_a[p];
            assign port_evt[p] = |st_a[p];
        end
    endgenerate

    assign evt_irq = |port_evt;

    always_comb begin
        io_rdata = '0;
        if (io_rd && sel.occupied) begin
            case (sel.kind)
                REG_OUT:  io_rdata = out_a[sel.port];
                REG_IN:   io_rdata = pin_s[sel.port*PORT_W +: PORT_W];
                REG_EVEN: io_rdata = en_a[sel.port];
                REG_EVST: io_rdata = st_a[sel.port];
                default:  io_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_window_bank_chk.sv
module gpio_window_bank_chk
    import gpio_win_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] win_base,
    input logic              win_active,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              io_hit,
    input logic [PINS-1:0]   pin_in,
    input logic [PINS-1:0]   pin_out,
    input logic              evt_irq
);
    logic unused_chk;
    assign unused_chk = ^{win_base, io_addr, io_wdata, pin_in};

    AST_INACTIVE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !win_active |-> !io_hit); // R2

    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !io_hit |-> io_rdata == 8'h00); // R2

    AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> io_rdata == 8'h00); // R11

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && io_hit) |=> $stable(pin_out)); // R4

    AST_IRQ_DROP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(evt_irq) |-> $past(io_wr && io_hit)); // R9
endmodule

bind gpio_window_bank gpio_window_bank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_window_bank_bench.sv
module gpio_window_bank_bench;
    localparam int AW = 16;
    localparam logic [15:0] BASE = 16'h0300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] win_base = BASE;
    logic        win_active = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_hit, evt_irq;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] out_m [4];

    always #4 clk = ~clk;

    gpio_window_bank #(.ADDR_W(AW)) u_gpio_window_bank (.*);

    function automatic logic [3:0] port_off(input int p);
        case (p)
            0: return 4'd0;
            1: return 4'd4;
            2: return 4'd8;
            default: return 4'd10;
        endcase
    endfunction

    function automatic logic [31:0] out_model();
        return {out_m[3], out_m[2], out_m[1], out_m[0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        for (int p = 0; p < 4; p++) out_m[p] = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 irq", {31'd0, evt_irq}, 32'd0);
        for (int o = 0; o < 16; o++) begin
            rd(BASE + 16'(o), d);
            chk("R1 reg", {24'd0, d}, 32'd0);
        end

        // R11 read strobe low gives zero
        io_addr = BASE;
        #1 chk("R11 idle rdata", {24'd0, io_rdata}, 32'd0);

        // R3 R4 port offsets and readback
        for (int p = 0; p < 4; p++) begin
            out_m[p] = 8'h11 * 8'(p + 1);
            wr(BASE + 16'(port_off(p)), out_m[p]);
        end
        chk("R3 R4 pin_out map", pin_out, out_model());
        for (int p = 0; p < 4; p++) begin
            rd(BASE + 16'(port_off(p)), d);
            chk("R4 readback", {24'd0, d}, {24'd0, out_m[p]});
        end

        // R3 overlap: offset 10 is port 3 output, port 2 untouched
        wr(BASE + 16'd10, 8'h5A); out_m[3] = 8'h5A;
        chk("R3 overlap write", pin_out, out_model());

        // R5 synchronizer latency
        @(negedge clk) pin_in = 32'hA5C3_3C96;
        rd(BASE + 16'd1, d);
        chk("R5 one edge old", {24'd0, d}, 32'h00);
        rd(BASE + 16'd1, d);
        chk("R5 two edges new", {24'd0, d}, 32'h96);
        rd(BASE + 16'd11, d);
        chk("R3 overlap input port3", {24'd0, d}, 32'hA5);
        rd(BASE + 16'd9, d);
        chk("R3 input port2", {24'd0, d}, 32'hC3);
        @(negedge clk) pin_in = 32'h0;
        idle(4);

        // R6 event set on enabled rising edges
        wr(BASE + 16'd2, 8'h0F);
        @(negedge clk) pin_in[7:0] = 8'hFF;
        idle(4);
        rd(BASE + 16'd3, d);
        chk("R6 rise enabled", {24'd0, d}, 32'h0F);
        chk("R9 irq set", {31'd0, evt_irq}, 32'd1);
        @(negedge clk) pin_in[7:0] = 8'h00;
        idle(4);
        rd(BASE + 16'd3, d);
        chk("R6 falling no change", {24'd0, d}, 32'h0F);

        // R7 clearing
        wr(BASE + 16'd3, 8'hF5);
        rd(BASE + 16'd3, d);
        chk("R7 clear ones keep zeros", {24'd0, d}, 32'h0A);
        chk("R9 irq still set", {31'd0, evt_irq}, 32'd1);
        wr(BASE + 16'd3, 8'h0A);
        chk("R9 irq cleared", {31'd0, evt_irq}, 32'd0);

        // R6 port 1 event on pin 15 only
        wr(BASE + 16'd6, 8'h80);
        @(negedge clk) pin_in[15:8] = 8'hC1;
        idle(4);
        rd(BASE + 16'd7, d);
        chk("R6 port1 rise", {24'd0, d}, 32'h80);
        wr(BASE + 16'd7, 8'h80);
        chk("R7 port1 clear irq", {31'd0, evt_irq}, 32'd0);
        @(negedge clk) pin_in = 32'h0;
        idle(4);

        // R8 port 3 event registers
        wr(BASE + 16'd12, 8'hFF);
        wr(BASE + 16'd13, 8'hFF);
        rd(BASE + 16'd12, d);
        chk("R8 port3 enable", {24'd0, d}, 32'h0);
        @(negedge clk) pin_in[31:16] = 16'hFFFF;
        idle(4);
        rd(BASE + 16'd13, d);
        chk("R8 port3 status", {24'd0, d}, 32'h0);
        chk("R8 no irq", {31'd0, evt_irq}, 32'd0);
        @(negedge clk) pin_in = 32'h0;
        idle(3);

        // R10 unoccupied offsets
        wr(BASE + 16'd14, 8'hFF);
        wr(BASE + 16'd15, 8'hFF);
        rd(BASE + 16'd14, d);
        chk("R10 off14", {24'd0, d}, 32'h0);
        rd(BASE + 16'd15, d);
        chk("R10 off15", {24'd0, d}, 32'h0);
        chk("R10 no side effect", pin_out, out_model());

        // R2 outside window and inactive
        wr(BASE + 16'd16, 8'hEE);
        wr(BASE - 16'd1, 8'hEE);
        chk("R2 outside write", pin_out, out_model());
        @(negedge clk) win_active = 1'b0;
        wr(BASE, 8'h33);
        chk("R2 inactive write", pin_out, out_model());
        rd(BASE, d);
        chk("R2 inactive read", {24'd0, d}, 32'h0);
        @(negedge clk) win_active = 1'b1;

        // R2 random addresses around window
        for (int i = 0; i < 200; i++) begin
            logic [15:0] a;
            logic exp_hit;
            a = BASE - 16'd8 + 16'($urandom % 32);
            exp_hit = (a >= BASE) && (a < BASE + 16'd16);
            @(negedge clk) io_addr = a;
            #1 chk("R2 hit", {31'd0, io_hit}, {31'd0, exp_hit});
        end

        // R12 random single-pin read-modify-write
        for (int i = 0; i < 150; i++) begin
            int n, p, b;
            logic v;
            n = int'($urandom % 32);
            v = 1'($urandom);
            p = n / 8; b = n % 8;
            rd(BASE + 16'(port_off(p)), d);
            d[b] = v;
            wr(BASE + 16'(port_off(p)), d);
            out_m[p][b] = v;
            chk("R12 pin bit", {31'd0, pin_out[n]}, {31'd0, v});
            chk("R12 all pins", pin_out, out_model());
        end

        // R5 R12 random input patterns
        for (int i = 0; i < 40; i++) begin
            logic [31:0] pv;
            pv = $urandom;
            @(negedge clk) pin_in = pv;
            idle(2);
            for (int p = 0; p < 4; p++) begin
                rd(BASE + 16'(port_off(p)) + 16'd1, d);
                chk("R5 input", {24'd0, d}, {24'd0, pv[p*8 +: 8]});
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule